// File: doc/BRIEF.md
# Boundary-Scan Data Register Bank

This block holds the three serial data registers that sit between the test data input and the test data output of a boundary-scan test port. The first is a 48-cell boundary register with a parallel shadow stage. The second is a one-stage bypass register. The third is a 32-bit identification register. An external test-port state machine and instruction decoder supply a register select, a test-mode flag and three strobes: capture, shift and update. The bank loads, shifts and updates only the register that is selected. Unselected registers keep their contents.

The boundary cells come in four fields. At the top are four active-low output-enable cells. Below them are eight cells for the transceiver's clock and latch-enable control inputs. Then come 18 A-port I/O cells and 18 B-port I/O cells. In normal mode the bank only observes the pins. For an I/O pin that the core is currently driving, it captures the core's output value instead of the pin. In test mode the shadow stage takes over the pins. Every I/O pin whose group enable cell holds 0 drives its shadow value. All other pins stay undriven. The shadow keeps driving while the bypass register is in the scan path, which is how a clamp instruction is built.

Top module: `scan_dr_bank`

## Requirements
- R1: The boundary register is 48 cells long. A shift moves serial data in at cell 47, and `tdo_o` presents cell 0 while the boundary register is selected. Select encoding on `dr_sel_i`: 2'b00 bypass, 2'b01 boundary, 2'b10 identification, 2'b11 bypass.
- R2: While `trst_n` is low, boundary cells 47..44 are set to 1 in both the shift and the shadow stage. As a result, no pin is driven even when `test_mode_i` is 1.
- R3: A boundary capture loads the pins into the cells as follows:
  - Cells 44+k take `oe_pin_i[k]`.
  - Cells 36..43 take `ctl_pin_i[7:0]`.
  - Cell 18+i takes A pin i, and cell i takes B pin i.
  - Exception in normal mode: an I/O cell whose group enable pin is 0 captures the core value instead of the pin.
  - Group mapping: A pins 0..8 use enable k=0, A pins 9..17 use k=1, B pins 0..8 use k=2, and B pins 9..17 use k=3.
- R4: The bypass register captures 0 and forms a single stage between `tdi_i` and `tdo_o`.
- R5: The identification register captures 0x0008202F and shifts it out least significant bit first. Its low 12 bits are 0x02F.
- R6: The boundary shadow loads from the shift stage on the falling clock edge while `upd_dr_i` is high and the boundary register is selected. Otherwise the shadow is unchanged.
- R7: With `test_mode_i` at 1:
  - I/O pin i of a port is driven exactly when its group enable cell in the shadow is 0, and the driven value is that pin's shadow cell.
  - Every boundary cell captures from the pins.
- R8: Capture and shift strobes leave the shift stage of every unselected register unchanged.
- R9: With `test_mode_i` at 0 no pin enable is asserted. In test mode, with the bypass register selected, scans and updates leave the shadow unchanged, so the pins stay driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; capture and shift on the rising edge, update on the falling edge |
| trst_n | input | 1 | Asynchronous active-low reset of the bank |
| tdi_i | input | 1 | Serial test data in |
| cap_dr_i | input | 1 | Capture strobe for the selected register |
| shf_dr_i | input | 1 | Shift strobe for the selected register |
| upd_dr_i | input | 1 | Update strobe; shadow load on the falling edge |
| dr_sel_i | input | 2 | Register select (00/11 bypass, 01 boundary, 10 identification) |
| test_mode_i | input | 1 | 1 hands the pins to the boundary shadow |
| oe_pin_i | input | 4 | Active-low output-enable control inputs, group order k=0..3 |
| ctl_pin_i | input | 8 | Clock and latch-enable control inputs |
| a_pin_i | input | 18 | Values observed on the A-port pins |
| b_pin_i | input | 18 | Values observed on the B-port pins |
| a_core_i | input | 18 | Core logic values destined for the A port |
| b_core_i | input | 18 | Core logic values destined for the B port |
| tdo_o | output | 1 | Serial test data out, bit 0 of the selected register |
| a_drv_o | output | 18 | Test values for the A-port pins |
| a_drv_en_o | output | 18 | Per-pin drive enable for the A port |
| b_drv_o | output | 18 | Test values for the B-port pins |
| b_drv_en_o | output | 18 | Per-pin drive enable for the B port |

## Verification
The identification and bypass registers are scanned with nonzero serial input. This shows that nothing shifted in survives into the next capture, and that the bypass adds exactly one stage of delay. Boundary captures run under three pin patterns:
- all enables high, which shows that the pins are observed;
- a mixed enable pattern, which shows that output-mode groups observe the core rather than the pin;
- a test-mode pattern with all enables low, which shows that test mode ignores the core.

Preloaded shadows with different enable nibbles tell apart correct per-group drive from drive taken from the wrong cell. A bypass scan plus an update during test mode, followed by an uncaptured boundary shift, shows both the held shadow and the held shift stage.

// File: rtl/scan_dr_pkg.sv
`timescale 1ns/1ps
package scan_dr_pkg;

  typedef enum logic [1:0] {
    SEL_BYP = 2'b00,
    SEL_BSR = 2'b01,
    SEL_IDR = 2'b10,
    SEL_RSV = 2'b11
  } dr_sel_e;

  // Index of the output-enable cell that governs a pin of a port (A=0, B=1).
  function automatic int oe_index(input int port, input int pin,
                                  input int grp_w, input int grp_per_port);
    return port * grp_per_port + pin / grp_w;
  endfunction

  // Value an I/O cell captures: the core value when the core drives the pin
  // in normal mode, otherwise what the pin shows.
  function automatic logic io_capture(input logic test_mode, input logic oe_n,
                                      input logic pin_v, input logic core_v);
    return (!test_mode && !oe_n) ? core_v : pin_v;
  endfunction

endpackage

// File: rtl/scan_sreg.sv
`timescale 1ns/1ps
module scan_sreg #(
  parameter int          W       = 32,
  parameter logic [W-1:0] CAP_VAL = '0
) (
  input  logic tck,
  input  logic trst_n,
  input  logic cap_en,
  input  logic shf_en,
  input  logic tdi,
  output logic so
);
  logic [W-1:0] q;

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     q <= '0;
        else if (cap_en) q <= CAP_VAL;
        else if (shf_en) q <= tdi;
      end
    end else begin : g_chain
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     q <= '0;
        else if (cap_en) q <= CAP_VAL;
        else if (shf_en) q <= {tdi, q[W-1:1]};
      end
    end
  endgenerate

  assign so = q[0];
endmodule

// File: rtl/scan_bsr.sv
`timescale 1ns/1ps
module scan_bsr #(
  parameter int           W       = 48,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         cap_en,
  input  logic         shf_en,
  input  logic         upd_en,
  input  logic         tdi,
  input  logic [W-1:0] cap_vec,
  output logic [W-1:0] shift_q,
  output logic [W-1:0] shadow_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     shift_q <= RST_VAL;
    else if (cap_en) shift_q <= cap_vec;
    else if (shf_en) shift_q <= {tdi, shift_q[W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     shadow_q <= RST_VAL;
    else if (upd_en) shadow_q <= shift_q;
  end
endmodule

// File: rtl/scan_dr_bank.sv
`timescale 1ns/1ps
module scan_dr_bank
  import scan_dr_pkg::*;
#(
  parameter int              IO_W     = 18,
  parameter int              GRP_W    = 9,
  parameter int              CTL_W    = 8,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0008_202F
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi_i,
  input  logic              cap_dr_i,
  input  logic              shf_dr_i,
  input  logic              upd_dr_i,
  input  logic [1:0]        dr_sel_i,
  input  logic              test_mode_i,
  input  logic [3:0]        oe_pin_i,
  input  logic [CTL_W-1:0]  ctl_pin_i,
  input  logic [IO_W-1:0]   a_pin_i,
  input  logic [IO_W-1:0]   b_pin_i,
  input  logic [IO_W-1:0]   a_core_i,
  input  logic [IO_W-1:0]   b_core_i,
  output logic              tdo_o,
  output logic [IO_W-1:0]   a_drv_o,
  output logic [IO_W-1:0]   a_drv_en_o,
  output logic [IO_W-1:0]   b_drv_o,
  output logic [IO_W-1:0]   b_drv_en_o
);
  localparam int GRP_PER_PORT = IO_W / GRP_W;
  localparam int OE_W         = 2 * GRP_PER_PORT;
  localparam int B_LO         = 0;
  localparam int A_LO         = IO_W;
  localparam int CTL_LO       = 2 * IO_W;
  localparam int OE_LO        = CTL_LO + CTL_W;
  localparam int BSR_W        = OE_LO + OE_W;
  localparam logic [BSR_W-1:0] BSR_RST = {{OE_W{1'b1}}, {(BSR_W-OE_W){1'b0}}};

  dr_sel_e sel;
  assign sel = dr_sel_e'(dr_sel_i);

  // Named internal events, also observed by the bound checker.
  logic sel_bsr, sel_idr, sel_byp;
  logic cap_bsr, shf_bsr, upd_bsr;
  logic [BSR_W-1:0] cap_vec;
  logic [BSR_W-1:0] bsr_shift_q;
  logic [BSR_W-1:0] bsr_shadow_q;
  logic [OE_W-1:0]  shadow_oe_n;
  logic             byp_so, idr_so;

  assign sel_bsr = (sel == SEL_BSR);
  assign sel_idr = (sel == SEL_IDR);
  assign sel_byp = !sel_bsr && !sel_idr;
  assign cap_bsr = cap_dr_i && sel_bsr;
  assign shf_bsr = shf_dr_i && sel_bsr;
  assign upd_bsr = upd_dr_i && sel_bsr;

  // Capture vector: control inputs straight from the pins, I/O cells per pin.
  assign cap_vec[OE_LO  +: OE_W]  = oe_pin_i[OE_W-1:0];
  assign cap_vec[CTL_LO +: CTL_W] = ctl_pin_i;

  assign shadow_oe_n = bsr_shadow_q[OE_LO +: OE_W];

  generate
    for (genvar i = 0; i < IO_W; i++) begin : g_io
      localparam int AI = oe_index(0, i, GRP_W, GRP_PER_PORT);
      localparam int BI = oe_index(1, i, GRP_W, GRP_PER_PORT);
      assign cap_vec[A_LO+i] = io_capture(test_mode_i, oe_pin_i[AI], a_pin_i[i], a_core_i[i]);
      assign cap_vec[B_LO+i] = io_capture(test_mode_i, oe_pin_i[BI], b_pin_i[i], b_core_i[i]);
      assign a_drv_o[i]      = bsr_shadow_q[A_LO+i];
      assign b_drv_o[i]      = bsr_shadow_q[B_LO+i];
      assign a_drv_en_o[i]   = test_mode_i && !shadow_oe_n[AI];
      assign b_drv_en_o[i]   = test_mode_i && !shadow_oe_n[BI];
    end
  endgenerate

  scan_bsr #(.W(BSR_W), .RST_VAL(BSR_RST)) u_bsr (
    .tck(tck), .trst_n(trst_n), .cap_en(cap_bsr), .shf_en(shf_bsr),
    .upd_en(upd_bsr), .tdi(tdi_i), .cap_vec(cap_vec),
    .shift_q(bsr_shift_q), .shadow_q(bsr_shadow_q)
  );

  scan_sreg #(.W(1), .CAP_VAL(1'b0)) u_byp (
    .tck(tck), .trst_n(trst_n), .cap_en(cap_dr_i && sel_byp),
    .shf_en(shf_dr_i && sel_byp), .tdi(tdi_i), .so(byp_so)
  );

  scan_sreg #(.W(ID_W), .CAP_VAL(ID_VALUE)) u_idr (
    .tck(tck), .trst_n(trst_n), .cap_en(cap_dr_i && sel_idr),
    .shf_en(shf_dr_i && sel_idr), .tdi(tdi_i), .so(idr_so)
  );

  always_comb begin
    if (sel_bsr)      tdo_o = bsr_shift_q[0];
    else if (sel_idr) tdo_o = idr_so;
    else              tdo_o = byp_so;
  end
endmodule

// File: rtl/scan_dr_bank_chk.sv
`timescale 1ns/1ps
module scan_dr_bank_chk #(
  parameter int              BSR_W    = 48,
  parameter int              OE_W     = 4,
  parameter int              IO_W     = 18,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0008_202F
) (
  input logic             tck,
  input logic             trst_n,
  input logic             cap_dr_i,
  input logic             shf_dr_i,
  input logic             upd_dr_i,
  input logic [1:0]       dr_sel_i,
  input logic             test_mode_i,
  input logic             tdo_o,
  input logic [IO_W-1:0]  a_drv_en_o,
  input logic [IO_W-1:0]  b_drv_en_o,
  input logic [BSR_W-1:0] bsr_shift_q,
  input logic [OE_W-1:0]  shadow_oe_n,
  input logic [BSR_W-1:0] bsr_shadow_q
);
  AST_RESET_OE_SAFE: assert property (@(posedge tck) disable iff (!trst_n)
    ($rose(trst_n) && !upd_dr_i) |-> (&shadow_oe_n)); // R2

  AST_BYP_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_dr_i && dr_sel_i == 2'b00) ##1 (dr_sel_i == 2'b00) |-> (tdo_o == 1'b0)); // R4

  AST_ID_LSB_FIRST: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_dr_i && dr_sel_i == 2'b10) ##1 (dr_sel_i == 2'b10) |-> (tdo_o == ID_VALUE[0])); // R5

  AST_SHADOW_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    !(upd_dr_i && dr_sel_i == 2'b01) |-> $stable(bsr_shadow_q)); // R6

  AST_UNSELECTED_BSR_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
    ((cap_dr_i || shf_dr_i) && dr_sel_i != 2'b01) |=> $stable(bsr_shift_q)); // R8

  AST_NORMAL_NO_DRIVE: assert property (@(posedge tck) disable iff (!trst_n)
    !test_mode_i |-> (a_drv_en_o == '0 && b_drv_en_o == '0)); // R9
endmodule

bind scan_dr_bank scan_dr_bank_chk #(
  .BSR_W(BSR_W), .OE_W(OE_W), .IO_W(IO_W), .ID_W(ID_W), .ID_VALUE(ID_VALUE)
) u_chk (
  .tck(tck), .trst_n(trst_n), .cap_dr_i(cap_dr_i), .shf_dr_i(shf_dr_i),
  .upd_dr_i(upd_dr_i), .dr_sel_i(dr_sel_i), .test_mode_i(test_mode_i),
  .tdo_o(tdo_o), .a_drv_en_o(a_drv_en_o), .b_drv_en_o(b_drv_en_o),
  .bsr_shift_q(bsr_shift_q), .shadow_oe_n(shadow_oe_n),
  .bsr_shadow_q(bsr_shadow_q)
);

// File: tb/sim_scan_dr_bank.sv
`timescale 1ns/1ps
module sim_scan_dr_bank;
  localparam int NIO = 18;

  logic tck = 1'b0, trst_n = 1'b0, tdi = 1'b0;
  logic cap = 1'b0, shf = 1'b0, upd = 1'b0, tmode = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [3:0] oe_pin = 4'hF;
  logic [7:0] ctl_pin = 8'h00;
  logic [NIO-1:0] a_pin = '0, b_pin = '0, a_core = '0, b_core = '0;
  logic tdo;
  logic [NIO-1:0] a_drv, a_en, b_drv, b_en;

  int nchk = 0, nerr = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #2 tck = ~tck; // 250 MHz

  scan_dr_bank u0 (
    .tck(tck), .trst_n(trst_n), .tdi_i(tdi), .cap_dr_i(cap), .shf_dr_i(shf),
    .upd_dr_i(upd), .dr_sel_i(sel), .test_mode_i(tmode), .oe_pin_i(oe_pin),
    .ctl_pin_i(ctl_pin), .a_pin_i(a_pin), .b_pin_i(b_pin), .a_core_i(a_core),
    .b_core_i(b_core), .tdo_o(tdo), .a_drv_o(a_drv), .a_drv_en_o(a_en),
    .b_drv_o(b_drv), .b_drv_en_o(b_en)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: one expected serial bit per shift cycle, compared mid-cycle.
  always @(negedge tck) begin
    if (shf && exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({63'd0, tdo}, {63'd0, e}, t);
    end
  end

  task automatic cyc();
    @(posedge tck);
    #1;
  endtask

  task automatic capture(input logic [1:0] s);
    sel = s; cap = 1'b1; cyc(); cap = 1'b0;
  endtask

  task automatic shift_bits(input int n, input logic [63:0] din,
                            input logic [63:0] dexp, input string tag);
    for (int k = 0; k < n; k++) begin
      tdi = din[k];
      shf = 1'b1;
      exp_q.push_back(dexp[k]);
      tag_q.push_back(tag);
      cyc();
    end
    shf = 1'b0;
  endtask

  task automatic update();
    upd = 1'b1; cyc(); upd = 1'b0;
  endtask

  // Expected boundary capture, laid out from the R3/R7 field map.
  function automatic logic [47:0] exp_cap(input logic tm);
    logic [47:0] v;
    v = '0;
    for (int k = 0; k < 4; k++) v[44+k] = oe_pin[k];
    for (int k = 0; k < 8; k++) v[36+k] = ctl_pin[k];
    for (int i = 0; i < NIO; i++) begin
      int g;
      g = (i < 9) ? 0 : 1;
      v[18+i] = (!tm && oe_pin[g] == 1'b0)   ? a_core[i] : a_pin[i];
      v[i]    = (!tm && oe_pin[2+g] == 1'b0) ? b_core[i] : b_pin[i];
    end
    return v;
  endfunction

  task automatic check_drive(input logic [47:0] sh, input logic tm, input string tag);
    logic [NIO-1:0] ea_en, eb_en;
    for (int i = 0; i < NIO; i++) begin
      int g;
      g = (i < 9) ? 0 : 1;
      ea_en[i] = tm & ~sh[44+g];
      eb_en[i] = tm & ~sh[46+g];
    end
    check({46'd0, a_en}, {46'd0, ea_en}, {tag, " a_en"});
    check({46'd0, b_en}, {46'd0, eb_en}, {tag, " b_en"});
    if (tm) begin
      check({46'd0, a_drv & ea_en}, {46'd0, sh[35:18] & ea_en}, {tag, " a_drv"});
      check({46'd0, b_drv & eb_en}, {46'd0, sh[17:0]  & eb_en}, {tag, " b_drv"});
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog expired");
    report();
  end

  localparam logic [47:0] D1 = 48'hA7C3_E917_B2D4; // enables 1010: A g0, B g0 drive
  localparam logic [47:0] D2 = 48'h05B6_29CE_7A13; // enables 0000: all drive
  localparam logic [31:0] IDV = 32'h0008_202F;

  initial begin
    repeat (3) cyc();
    trst_n = 1'b1;
    cyc();
    // R2: reset leaves enable cells at 1, so test mode drives nothing
    tmode = 1'b1; #0.5;
    check({46'd0, a_en}, 64'd0, "R2 reset a_en");
    check({46'd0, b_en}, 64'd0, "R2 reset b_en");
    tmode = 1'b0; #0.5;

    // R5: identification, twice, with shifted-in data that must not stick
    capture(2'b10);
    shift_bits(32, 64'h5A5A_C3C3, {32'd0, IDV}, "R5 idcode");
    capture(2'b10);
    shift_bits(32, 64'hFFFF_FFFF, {32'd0, IDV}, "R5 idcode again");
    check({52'd0, IDV[11:0]}, 64'h02F, "R5 low field");

    // R4: bypass is one stage, captures 0; code 11 also selects bypass
    capture(2'b00);
    shift_bits(4, 64'b1101, 64'b1010, "R4 bypass");
    capture(2'b11);
    shift_bits(3, 64'b011, 64'b110, "R4 bypass sel11");

    // R1/R3: sample, all enables high -> pins observed
    oe_pin = 4'hF; ctl_pin = 8'h96;
    a_pin = 18'h2A5C3; b_pin = 18'h15A3C; a_core = 18'h3FFFF; b_core = 18'h00000;
    capture(2'b01);
    shift_bits(48, {16'd0, D1}, {16'd0, exp_cap(1'b0)}, "R1 R3 sample pins");

    // R3: mixed enables -> output-mode groups observe the core
    oe_pin = 4'b0110; ctl_pin = 8'h3C; a_core = 18'h1E0F5; b_core = 18'h2B3D1;
    capture(2'b01);
    shift_bits(48, {16'd0, D1}, {16'd0, exp_cap(1'b0)}, "R3 sample core");

    // R6/R9/R7: update shadow with D1, normal then test mode drive
    update();
    #0.5;
    check_drive(D1, 1'b0, "R9 normal no drive");
    tmode = 1'b1; #0.5;
    check_drive(D1, 1'b1, "R7 extest drive D1");

    // R7: test-mode capture takes pins even for output-mode cells
    oe_pin = 4'b0000; a_pin = 18'h0F0F0; b_pin = 18'h33CC3;
    capture(2'b01);
    shift_bits(48, {16'd0, D1}, {16'd0, exp_cap(1'b1)}, "R7 extest capture");

    // R9: bypass scan + update in test mode leaves drive untouched
    capture(2'b00);
    shift_bits(5, 64'b10110, 64'b01100, "R9 clamp bypass");
    update();
    #0.5;
    check_drive(D1, 1'b1, "R9 clamp hold");

    // R8: boundary shift stage held during bypass activity
    sel = 2'b01;
    shift_bits(48, {16'd0, D2}, {16'd0, D1}, "R8 unselected hold");
    #0.5;
    check_drive(D1, 1'b1, "R6 no update yet");
    update();
    #0.5;
    check_drive(D2, 1'b1, "R6 update D2");

    // R2: reset in test mode releases every pin
    trst_n = 1'b0; #0.5;
    check({46'd0, a_en}, 64'd0, "R2 rereset a_en");
    check({46'd0, b_en}, 64'd0, "R2 rereset b_en");
    cyc();
    trst_n = 1'b1; tmode = 1'b0;
    repeat (2) cyc();
    check(exp_q.size(), 0, "R1 scoreboard drained");
    report();
  end
endmodule